// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does this by walking a two-level page table that lives in ordinary memory.

A requester presents the virtual address with a valid/ready handshake. The walker then reads one entry from the top-level directory, whose page is named by a root base input. If that entry is valid, it reads one entry from the second-level table that the directory entry names. It finishes with a one-cycle completion pulse that carries either the assembled physical address or a fault flag.

Memory is reached through a word-read port. A request is offered with valid and accepted with ready. The data returns later on a response strobe, after any number of idle cycles. Only one translation is in flight at a time. While a walk is running, the requester sees ready low.

Top module: `vat_walker`

## Requirements
- R1: While reset is applied, and on the first sampled cycle after it is released, req_ready is 1 and mem_req_valid, resp_done and resp_fault are all 0.
- R2: The virtual address is split into three fields: the directory index is bits [31:22], the table index is bits [21:12] and the byte offset is bits [11:0].
- R3: The first memory read of every walk is at address {root_base[31:12], va[31:22], 2'b00}. Bits [11:0] of root_base have no effect.
- R4: An entry is valid when its bit 0 is 1, and bits [31:12] of the entry hold a frame number. When the directory entry is valid, the second read is at {dir_entry[31:12], va[21:12], 2'b00}.
- R5: When the directory entry has bit 0 clear, the walk makes exactly one read, issues no second read, and ends with resp_fault.
- R6: When the second-level entry has bit 0 clear, the walk ends with resp_fault after two reads, and resp_paddr reads 0 during the fault pulse.
- R7: On a successful walk, resp_done pulses with resp_paddr = {pte[31:12], va[11:0]}. Entry bits [11:1] have no effect on the result.
- R8: resp_done and resp_fault are never high together. Each stays high for exactly one cycle, and req_ready is 1 in the cycle that follows.
- R9: A request is taken only while req_ready is 1. req_ready is 0 from the cycle after acceptance until the completion pulse ends, and req_valid has no effect during that time.
- R10: Once mem_req_valid is raised, it and mem_req_addr stay unchanged until a cycle where mem_req_ready is 1.
- R11: Any number of wait cycles between a memory request and its response is accepted. No new memory request is made while a response is outstanding, and a walk never makes more than two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical address of the directory page, sampled at acceptance |
| mem_req_valid | output | 1 | Memory word read requested |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| resp_done | output | 1 | One-cycle pulse: translation succeeded |
| resp_fault | output | 1 | One-cycle pulse: page fault |
| resp_paddr | output | 32 | Physical address, valid with resp_done; 0 with resp_fault |

## Verification
Some rules are checked by assertions on every cycle:
- the entry address of each read, rebuilt from the accepted address and the captured directory word;
- that the memory request is held steady under back-pressure;
- that a single read is outstanding at a time and no third read is ever made;
- that the completion pulses are exclusive and last one cycle;
- that the offset is carried through, and that the address is zero on a fault.

Other behaviour shows only in the bench's scenarios, because it depends on what memory held. This covers whether a walk faults at the first level or at the second, the exact frame placed into the result, that ignored entry bits and low base bits have no effect, and that requests offered during a busy walk really leave no trace.

// File: rtl/vat_pkg.sv
package vat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_PTE,
    ST_WT_PTE,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam int unsigned LEVELS = 2;

endpackage

// File: rtl/vat_rst_sync.sv
module vat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/vat_field_split.sv
module vat_field_split
  import vat_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [VA_W-1:0]               va_i,
  output logic [LEVELS-1:0][IDX_W-1:0]  idx_o,
  output logic [OFF_W-1:0]              off_o
);

  // Level 0 is the directory index (topmost bits), deeper levels follow below it.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned TOP = VA_W - 1 - l * IDX_W;
    assign idx_o[l] = va_i[TOP -: IDX_W];
  end

  assign off_o = va_i[OFF_W-1:0];

endmodule

// File: rtl/vat_entry_addr.sv
module vat_entry_addr #(
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ESZ_LOG = 2
) (
  input  logic [PA_W-OFF_W-1:0] frame_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [PA_W-1:0]       addr_o
);

  localparam int unsigned PAD_W = PA_W - IDX_W - ESZ_LOG;

  logic [PA_W-1:0] base_w;
  logic [PA_W-1:0] disp_w;

  assign base_w = {frame_i, {OFF_W{1'b0}}};
  assign disp_w = {{PAD_W{1'b0}}, idx_i, {ESZ_LOG{1'b0}}};
  assign addr_o = base_w + disp_w;

endmodule

// File: rtl/vat_seq.sv
module vat_seq
  import vat_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [VA_W-1:0]               req_vaddr_i,
  input  logic [PA_W-1:0]               root_base_i,
  output logic [VA_W-1:0]               va_o,
  input  logic [LEVELS-1:0][IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]              off_i,
  output logic [PA_W-OFF_W-1:0]         tbl_frame_o,
  output logic [IDX_W-1:0]              tbl_idx_o,
  input  logic [PA_W-1:0]               ent_addr_i,
  output logic                          mem_req_valid_o,
  input  logic                          mem_req_ready_i,
  output logic [PA_W-1:0]               mem_req_addr_o,
  input  logic                          mem_rsp_valid_i,
  input  logic [PA_W-1:0]               mem_rsp_data_i,
  output logic                          done_o,
  output logic                          fault_o,
  output logic [PA_W-1:0]               paddr_o
);

  localparam int unsigned FR_W = PA_W - OFF_W;

  walk_state_e state_q, state_d;

  logic [VA_W-1:0]  va_q;
  logic [FR_W-1:0]  base_frame_q;
  logic [FR_W-1:0]  next_frame_q;
  logic [PA_W-1:0]  paddr_q, paddr_d;

  logic             accept;
  logic             dir_rsp;
  logic             pte_rsp;
  logic             ent_valid;
  logic [FR_W-1:0]  ent_frame;
  logic             va_en, base_en, next_en, paddr_en;
  logic [OFF_W-2:0] unused_ent_bits;
  logic [OFF_W-1:0] unused_base_bits;

  assign ent_valid        = mem_rsp_data_i[0];
  assign ent_frame        = mem_rsp_data_i[PA_W-1:OFF_W];
  assign unused_ent_bits  = mem_rsp_data_i[OFF_W-1:1];
  assign unused_base_bits = root_base_i[OFF_W-1:0];

  assign accept  = (state_q == ST_IDLE)   && req_valid_i;
  assign dir_rsp = (state_q == ST_WT_DIR) && mem_rsp_valid_i;
  assign pte_rsp = (state_q == ST_WT_PTE) && mem_rsp_valid_i;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i)     state_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_req_ready_i) state_d = ST_WT_DIR;
      ST_WT_DIR: if (mem_rsp_valid_i) state_d = ent_valid ? ST_RD_PTE : ST_FAULT;
      ST_RD_PTE: if (mem_req_ready_i) state_d = ST_WT_PTE;
      ST_WT_PTE: if (mem_rsp_valid_i) state_d = ent_valid ? ST_DONE : ST_FAULT;
      ST_DONE:                        state_d = ST_IDLE;
      ST_FAULT:                       state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  // Clock enables and data for the holding registers
  assign va_en    = accept;
  assign base_en  = accept;
  assign next_en  = dir_rsp;
  assign paddr_en = pte_rsp || (dir_rsp && !ent_valid);

  always_comb begin
    paddr_d = '0;
    if (pte_rsp && ent_valid) begin
      paddr_d = {ent_frame, off_i};
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q         <= '0;
      base_frame_q <= '0;
      next_frame_q <= '0;
      paddr_q      <= '0;
    end else begin
      if (va_en)    va_q         <= req_vaddr_i;
      if (base_en)  base_frame_q <= root_base_i[PA_W-1:OFF_W];
      if (next_en)  next_frame_q <= ent_frame;
      if (paddr_en) paddr_q      <= paddr_d;
    end
  end

  // Table selection for the entry-address adder
  always_comb begin
    if (state_q == ST_RD_PTE) begin
      tbl_frame_o = next_frame_q;
      tbl_idx_o   = idx_i[1];
    end else begin
      tbl_frame_o = base_frame_q;
      tbl_idx_o   = idx_i[0];
    end
  end

  assign va_o            = va_q;
  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_RD_DIR) || (state_q == ST_RD_PTE);
  assign mem_req_addr_o  = ent_addr_i;
  assign done_o          = (state_q == ST_DONE);
  assign fault_o         = (state_q == ST_FAULT);
  assign paddr_o         = paddr_q;

endmodule

// File: rtl/vat_walker.sv
module vat_walker
  import vat_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned ESZ_LOG    = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PA_W-1:0]  mem_rsp_data,
  output logic             resp_done,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr
);

  localparam int unsigned FR_W = PA_W - OFF_W;

  logic                         rst_n_sync;
  logic [VA_W-1:0]              va_held;
  logic [LEVELS-1:0][IDX_W-1:0] idx_w;
  logic [OFF_W-1:0]             off_w;
  logic [FR_W-1:0]              tbl_frame_w;
  logic [IDX_W-1:0]             tbl_idx_w;
  logic [PA_W-1:0]              ent_addr_w;

  vat_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  vat_field_split #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_split (
    .va_i  (va_held),
    .idx_o (idx_w),
    .off_o (off_w)
  );

  vat_entry_addr #(
    .PA_W    (PA_W),
    .OFF_W   (OFF_W),
    .IDX_W   (IDX_W),
    .ESZ_LOG (ESZ_LOG)
  ) u_eaddr (
    .frame_i (tbl_frame_w),
    .idx_i   (tbl_idx_w),
    .addr_o  (ent_addr_w)
  );

  vat_seq #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n_sync),
    .req_valid_i     (req_valid),
    .req_ready_o     (req_ready),
    .req_vaddr_i     (req_vaddr),
    .root_base_i     (root_base),
    .va_o            (va_held),
    .idx_i           (idx_w),
    .off_i           (off_w),
    .tbl_frame_o     (tbl_frame_w),
    .tbl_idx_o       (tbl_idx_w),
    .ent_addr_i      (ent_addr_w),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_ready_i (mem_req_ready),
    .mem_req_addr_o  (mem_req_addr),
    .mem_rsp_valid_i (mem_rsp_valid),
    .mem_rsp_data_i  (mem_rsp_data),
    .done_o          (resp_done),
    .fault_o         (resp_fault),
    .paddr_o         (resp_paddr)
  );

endmodule

// File: rtl/vat_walker_chk.sv
module vat_walker_chk #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ESZ_LOG = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [PA_W-1:0]  root_base,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [PA_W-1:0]  mem_rsp_data,
  input logic             resp_done,
  input logic             resp_fault,
  input logic [PA_W-1:0]  resp_paddr
);

  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] ent1_q;
  logic [1:0]      hs_cnt;
  logic            outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      base_q  <= '0;
      ent1_q  <= '0;
      hs_cnt  <= '0;
      outst_q <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        va_q   <= req_vaddr;
        base_q <= root_base;
        hs_cnt <= '0;
      end
      if (mem_req_valid && mem_req_ready) begin
        outst_q <= 1'b1;
        if (hs_cnt != 2'd3) hs_cnt <= hs_cnt + 2'd1;
      end
      if (mem_rsp_valid && outst_q) begin
        outst_q <= 1'b0;
        if (hs_cnt == 2'd1) ent1_q <= mem_rsp_data;
      end
    end
  end

  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && hs_cnt == 2'd0) |->
      mem_req_addr == {base_q[PA_W-1:OFF_W], va_q[VA_W-1 -: IDX_W], {ESZ_LOG{1'b0}}});

  p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && hs_cnt == 2'd1) |->
      (ent1_q[0] && mem_req_addr ==
        {ent1_q[PA_W-1:OFF_W], va_q[VA_W-IDX_W-1 -: IDX_W], {ESZ_LOG{1'b0}}}));

  p_no_third_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> hs_cnt < 2'd2);

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_paddr == '0);

  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_fault));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done || resp_fault) |=> (!resp_done && !resp_fault && req_ready));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_single_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst_q);

endmodule

bind vat_walker vat_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .root_base     (root_base),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .resp_done     (resp_done),
  .resp_fault    (resp_fault),
  .resp_paddr    (resp_paddr)
);

// File: tb/vat_walker_tb_top.sv
`timescale 1ns/100ps
module vat_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [31:0] root_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        resp_done;
  logic        resp_fault;
  logic [31:0] resp_paddr;

  int n_vec = 0;
  int n_bad = 0;

  // memory model bookkeeping
  int          rd_cnt;
  logic [31:0] rd_log [0:3];
  logic [31:0] ov_a [0:5];
  logic [31:0] ov_d [0:5];

  always #2.5 clk = ~clk;

  vat_walker dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .root_base     (root_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .resp_done     (resp_done),
    .resp_fault    (resp_fault),
    .resp_paddr    (resp_paddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory contents: directed overrides first, otherwise a hashed word whose
  // bit 0 is clear for one address in eight, with junk in bits [11:1].
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    for (int i = 0; i < 6; i++) if (ov_a[i] == a) return ov_d[i];
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h[0] = |h[3:1];
    return h;
  endfunction

  // Memory responder: picks ready at each falling edge, answers after a random delay.
  initial begin : mem_model
    logic        pend;
    logic [31:0] pend_addr;
    int          wait_cnt;
    logic        hold_pend;
    logic [31:0] hold_addr;
    pend = 1'b0; pend_addr = '0; wait_cnt = 0; hold_pend = 1'b0; hold_addr = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (hold_pend) begin
        chk(mem_req_valid && mem_req_addr == hold_addr, "R10 request held under back-pressure",
            mem_req_addr, hold_addr);
      end
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = $urandom;
      if (pend) begin
        if (wait_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend_addr);
          pend = 1'b0;
        end else begin
          wait_cnt--;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      hold_pend = mem_req_valid && !mem_req_ready;
      hold_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend      = 1'b1;
        pend_addr = mem_req_addr;
        wait_cnt  = $urandom % 5;
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  task automatic do_walk(input logic [31:0] va, input logic [31:0] base, input bit poke);
    logic        ef;
    logic [31:0] ep, a1, a2, d1, d2;
    int          en, cyc;
    bit          busy_bad;
    a1 = {base[31:12], va[31:22], 2'b00};
    d1 = mem_word(a1);
    a2 = {d1[31:12], va[21:12], 2'b00};
    d2 = mem_word(a2);
    if (!d1[0])      begin ef = 1'b1; en = 1; ep = '0; end
    else if (!d2[0]) begin ef = 1'b1; en = 2; ep = '0; end
    else             begin ef = 1'b0; en = 2; ep = {d2[31:12], va[11:0]}; end

    @(negedge clk);
    req_vaddr = va; root_base = base; req_valid = 1'b1; rd_cnt = 0;
    chk(req_ready == 1'b1, "R9 ready while idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (poke) begin
      req_vaddr = $urandom; root_base = $urandom;
    end else begin
      req_valid = 1'b0;
    end
    cyc = 0; busy_bad = 0;
    while (!(resp_done || resp_fault) && cyc < 400) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(!busy_bad && cyc < 400, "R9 R11 busy walk completes with ready low", cyc, 32'd0);
    chk(resp_fault == ef && resp_done == !ef, "R5 R6 outcome flag", {30'd0, resp_done, resp_fault},
        {30'd0, !ef, ef});
    if (ef) chk(resp_paddr == 32'd0, "R6 address zero on fault", resp_paddr, 32'd0);
    else    chk(resp_paddr == ep, "R7 physical address", resp_paddr, ep);
    chk(rd_cnt == en, "R5 read count", rd_cnt, en);
    chk(rd_log[0] == a1, "R3 directory entry address", rd_log[0], a1);
    if (en == 2) chk(rd_log[1] == a2, "R4 table entry address", rd_log[1], a2);
    @(negedge clk);
    chk(!resp_done && !resp_fault && req_ready, "R8 single-cycle pulse then idle",
        {29'd0, resp_done, resp_fault, req_ready}, 32'd1);
    chk(rd_cnt == en, "R11 no stray read after completion", rd_cnt, en);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rd_cnt = 0;
    for (int i = 0; i < 4; i++) rd_log[i] = '0;
    ov_a[0] = 32'h0010_0004; ov_d[0] = 32'h0020_0FFF;  // valid dir, junk low bits
    ov_a[1] = 32'h0020_0008; ov_d[1] = 32'h0009_C001;  // final frame 0x0009C
    ov_a[2] = 32'h0010_000C; ov_d[2] = 32'h1234_5FFE;  // invalid dir
    ov_a[3] = 32'h0010_0014; ov_d[3] = 32'h0030_0001;  // valid dir
    ov_a[4] = 32'h0030_001C; ov_d[4] = 32'hFFFF_FFFE;  // invalid table entry
    ov_a[5] = 32'hFFFF_FFFF; ov_d[5] = 32'h0;
    req_valid = 1'b0; req_vaddr = '0; root_base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !resp_done && !resp_fault, "R1 reset state",
        {28'd0, req_ready, mem_req_valid, resp_done, resp_fault}, 32'h8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_req_valid && !resp_done && !resp_fault, "R1 state after release",
        {28'd0, req_ready, mem_req_valid, resp_done, resp_fault}, 32'h8);

    // R2 R7: worked example, base carries junk in its low 12 bits (R3)
    do_walk(32'h0040_2ABC, 32'h0010_0ABC, 1'b0);
    // R5: directory entry invalid
    do_walk(32'h00C0_0123, 32'h0010_0000, 1'b0);
    // R6: table entry invalid
    do_walk(32'h0140_7456, 32'h0010_0000, 1'b0);
    // R9: requests offered during a busy walk are ignored
    do_walk(32'h0040_2ABC, 32'h0010_0000, 1'b1);
    // R2 boundary indices
    do_walk(32'hFFFF_FFFF, 32'hFFFF_F000, 1'b0);
    do_walk(32'h0000_0000, 32'h0000_0000, 1'b0);

    for (int n = 0; n < 400; n++) begin
      do_walk($urandom, $urandom, ($urandom % 3) == 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule